// File: doc/BRIEF.md
# Configuration Bitstream Loader

This peripheral takes a configuration image from a host, one 32-bit word at a time, and hands it to the configuration port of a target device. The host reaches it through a word-wide register interface. Before it starts the loader, the host sets the number of bytes the image holds. Image words are then written into a data window that feeds an internal FIFO. The loader drains the FIFO toward the target, one word per cycle whenever the target is ready, and counts the bytes it has delivered.

The block raises a level interrupt in two cases. The first is when the delivered byte count equals the preset total while the target reports configuration done. The second is when any error is recorded: an error reported by the target, or a push into a full FIFO. The interrupt is acknowledged in only one way, by clearing the enable bit. Clearing it also flushes the FIFO, the byte count and the error flags. In DMA mode the block raises a request line whenever the FIFO has room for half its depth, so that an external engine can fill it in bursts. A control bit drives the target's configuration reset.

Top module: `cfg_stream_loader`

## Requirements
- R1: The FIFO-size register (0x48) always reads FIFO_DEPTH*4 bytes (64 at default). The FIFO-used register (0x4C) reads four times the number of words held.
- R2: While enabled, each write to the data window (0x3000) pushes one word. While disabled (control bit 0 low), data-window writes have no effect and FIFO-used stays 0.
- R3: Words reach the target in write order, each as a one-cycle `tgt_valid` pulse, issued only in a cycle where `tgt_ready` was high. The current-count register (0x54) grows by 4 per word.
- R4: Draining stops once the current count reaches the total-count register (0x50). Words beyond the total stay in the FIFO.
- R5: `irq` rises when current count equals total and `tgt_done` is high. With `tgt_done` low, reaching the total raises no interrupt.
- R6: A high bit k of `tgt_err` while enabled sets status bit k+2 (status bits 15:2). It raises `irq` and halts draining.
- R7: A data-window write while the FIFO is full is dropped, sets status bit 1 and raises `irq`.
- R8: Writing the control register (0x40) with bit 0 clear drops `irq` by the second clock edge. It also empties the FIFO, zeroes the current count and clears the status error bits.
- R9: `tgt_reset_n` is the inverse of control bit 1. Writing 3 and then 0 pulses it low and releases it.
- R10: With control bits 0 and 2 set and no interrupt pending, `dma_req` is high exactly when the FIFO has at least FIFO_DEPTH/2 free words. It is never high in CPU mode (bit 2 clear).
- R11: Status bit 18 mirrors `tgt_done`.
- R12: After reset: `irq`, `dma_req` and `tgt_valid` are low, `tgt_reset_n` is high, control is 0 and status is 0 while `tgt_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dma_req | output | 1 | Burst request to an external DMA engine |
| irq | output | 1 | Completion or error interrupt, level |
| tgt_reset_n | output | 1 | Target configuration reset, active low |
| tgt_valid | output | 1 | A word is presented to the target this cycle |
| tgt_data | output | 32 | Word presented to the target |
| tgt_ready | input | 1 | Target can take a word |
| tgt_done | input | 1 | Target reports configuration complete |
| tgt_err | input | 14 | Target error flags, one per status bit 15:2 |

## Verification
Three conditions are the hardest to reach from the ports. One is the total count reached while the target has not yet reported done. The others are a full FIFO at the moment of a push, and a target error that lands while words are still queued. The bench gets to them by holding `tgt_ready` low so the FIFO fills and stays put, and by taking over `tgt_done` from its automatic target model so that done can lag behind the count. A sweep over image lengths from one word up past the FIFO depth uses varying ready patterns, in both CPU and DMA filling modes. Each delivered word is compared against a computed pattern.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int unsigned OFS_CTRL  = 32'h0040;
  localparam int unsigned OFS_STAT  = 32'h0044;
  localparam int unsigned OFS_SIZE  = 32'h0048;
  localparam int unsigned OFS_USED  = 32'h004C;
  localparam int unsigned OFS_TOTAL = 32'h0050;
  localparam int unsigned OFS_CUR   = 32'h0054;
  localparam int unsigned OFS_DATA  = 32'h3000;

  localparam int CTL_EN  = 0;
  localparam int CTL_RST = 1;
  localparam int CTL_DMA = 2;
  localparam int CTL_W   = 3;

  localparam int ST_OVF  = 1;
  localparam int ST_DONE = 18;
  localparam int ERR_W   = 14;
  localparam int WORD_BYTES = 4;

  function automatic logic [31:0] words_to_bytes(input logic [31:0] words);
    return words * WORD_BYTES;
  endfunction

  function automatic logic room_for_burst(input logic [31:0] free_words,
                                          input logic [31:0] depth);
    return free_words >= (depth >> 1);
  endfunction
endpackage

// File: rtl/cfgl_fifo.sv
module cfgl_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R7
  full_push_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> count == CW'(DEPTH));
endmodule

// File: rtl/cfgl_drain.sv
module cfgl_drain #(
  parameter int W     = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] total,
  input  logic             hold,
  input  logic             fifo_empty,
  input  logic [W-1:0]     fifo_rdata,
  input  logic             tgt_ready,
  input  logic             tgt_done,
  output logic             pop,
  output logic [CNT_W-1:0] cur,
  output logic             tgt_valid,
  output logic [W-1:0]     tgt_data,
  output logic             irq
);
  import cfgl_pkg::*;

  logic below_total, reached;

  assign below_total = (cur < total);
  assign pop     = en && !fifo_empty && tgt_ready && !hold && !irq && below_total;
  assign reached = en && (cur == total) && tgt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= '0;
      tgt_valid <= 1'b0;
      tgt_data  <= '0;
      irq       <= 1'b0;
    end else begin
      tgt_valid <= pop;
      if (pop) tgt_data <= fifo_rdata;
      if (!en)      cur <= '0;
      else if (pop) cur <= cur + CNT_W'(WORD_BYTES);
      if (!en)                  irq <= 1'b0;
      else if (reached || hold) irq <= 1'b1;
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> cur == $past(cur) + CNT_W'(WORD_BYTES));

  // R3
  valid_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> $past(tgt_ready));

  // R5
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(hold)) |-> $past(tgt_done));

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!irq && cur == '0));

  // R6
  halt_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pop);
endmodule

// File: rtl/cfgl_dmareq.sv
module cfgl_dmareq #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dma_mode,
  input  logic          irq,
  input  logic [CW-1:0] count,
  output logic          dma_req
);
  import cfgl_pkg::*;

  logic [31:0] free_words;

  assign free_words = 32'(DEPTH) - 32'(count);
  assign dma_req = en && dma_mode && !irq && room_for_burst(free_words, 32'(DEPTH));

  // R10
  no_req_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !irq);

  // R10
  no_req_cpu_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> !dma_req);
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dma_req,
  output logic              irq,
  output logic              tgt_reset_n,
  output logic              tgt_valid,
  output logic [31:0]       tgt_data,
  input  logic              tgt_ready,
  input  logic              tgt_done,
  input  logic [ERR_W-1:0]  tgt_err
);
  logic [CTL_W-1:0] ctrl_q;
  logic [31:0]      total_q;
  logic [ERR_W-1:0] terr_q;
  logic             ovf_q;
  logic             en, ctrl_wr, total_wr, data_wr, push_req;
  logic             fifo_full, fifo_empty, pop, hold;
  logic [CW-1:0]    fifo_count;
  logic [31:0]      fifo_rdata, cur, status;

  assign en       = ctrl_q[CTL_EN];
  assign ctrl_wr  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign total_wr = bus_we && (bus_addr == ADDR_W'(OFS_TOTAL));
  assign data_wr  = bus_we && (bus_addr == ADDR_W'(OFS_DATA));
  assign push_req = data_wr && en;
  assign hold     = ovf_q || (|terr_q) || (en && (|tgt_err));
  assign tgt_reset_n = !ctrl_q[CTL_RST];
  assign status = {13'b0, tgt_done, 2'b0, terr_q, ovf_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      total_q <= '0;
      terr_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (ctrl_wr)  ctrl_q  <= bus_wdata[CTL_W-1:0];
      if (total_wr) total_q <= bus_wdata;
      if (!en) begin
        terr_q <= '0;
        ovf_q  <= 1'b0;
      end else begin
        terr_q <= terr_q | tgt_err;
        if (push_req && fifo_full) ovf_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL):  bus_rdata = 32'(ctrl_q);
      ADDR_W'(OFS_STAT):  bus_rdata = status;
      ADDR_W'(OFS_SIZE):  bus_rdata = words_to_bytes(32'(FIFO_DEPTH));
      ADDR_W'(OFS_USED):  bus_rdata = words_to_bytes(32'(fifo_count));
      ADDR_W'(OFS_TOTAL): bus_rdata = total_q;
      ADDR_W'(OFS_CUR):   bus_rdata = cur;
      default:            bus_rdata = '0;
    endcase
  end

  cfgl_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en),
    .push(push_req), .wdata(bus_wdata), .pop(pop),
    .rdata(fifo_rdata), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  cfgl_drain #(.W(32), .CNT_W(32)) u_drain (
    .clk(clk), .rst_n(rst_n), .en(en), .total(total_q), .hold(hold),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .tgt_ready(tgt_ready), .tgt_done(tgt_done),
    .pop(pop), .cur(cur), .tgt_valid(tgt_valid), .tgt_data(tgt_data),
    .irq(irq)
  );

  cfgl_dmareq #(.DEPTH(FIFO_DEPTH)) u_dma (
    .clk(clk), .rst_n(rst_n), .en(en), .dma_mode(ctrl_q[CTL_DMA]),
    .irq(irq), .count(fifo_count), .dma_req(dma_req)
  );

  // R3
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  // R9
  reset_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[CTL_RST]) |=> !tgt_reset_n);

  // R6
  error_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (|tgt_err) && !ctrl_wr) |=> (|status[15:2]));

  // R7
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_full && !ctrl_wr) |=> status[ST_OVF]);
endmodule

// File: tb/sim_cfg_stream_loader.sv
`timescale 1ns/1ps
module sim_cfg_stream_loader;
  localparam int DEPTH = 16;
  localparam logic [15:0] A_CTRL = 16'h0040, A_STAT = 16'h0044, A_SIZE = 16'h0048,
                          A_USED = 16'h004C, A_TOTAL = 16'h0050, A_CUR = 16'h0054,
                          A_DATA = 16'h3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic dma_req, irq, tgt_reset_n, tgt_valid;
  logic [31:0] tgt_data;
  logic tgt_ready = 1'b0, tgt_done = 1'b0;
  logic [13:0] tgt_err = '0;

  int nchk = 0, nerr = 0;
  int rx_cnt = 0, rx_bad = 0, cyc = 0;
  int ready_mode = 0;
  bit done_auto = 1'b0;
  logic [31:0] exp_total = '0, seed = '0;

  always #5 clk = ~clk;

  cfg_stream_loader #(.FIFO_DEPTH(DEPTH), .ADDR_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req), .irq(irq),
    .tgt_reset_n(tgt_reset_n), .tgt_valid(tgt_valid), .tgt_data(tgt_data),
    .tgt_ready(tgt_ready), .tgt_done(tgt_done), .tgt_err(tgt_err)
  );

  function automatic logic [31:0] pat(input logic [31:0] s, input int i);
    return (s * 32'h0101_0101) ^ (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  // target model: collects words, compares with pattern, drives ready / done
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tgt_valid) begin
      if (tgt_data !== pat(seed, rx_cnt)) rx_bad = rx_bad + 1;
      rx_cnt = rx_cnt + 1;
    end
    case (ready_mode)
      0: tgt_ready <= 1'b0;
      1: tgt_ready <= 1'b1;
      default: tgt_ready <= ((cyc + rx_cnt) % 3) != 0;
    endcase
    if (done_auto) tgt_done <= (32'(rx_cnt) * 4 >= exp_total);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bread(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_irq(input int limit);
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic run_case(input int n, input bit dma, input int rmode);
    logic [31:0] u;
    int i, guard;
    seed = 32'(n) + (dma ? 32'h100 : 0);
    exp_total = 32'(n) * 4;
    rx_cnt = 0; rx_bad = 0;
    done_auto = 1'b1; ready_mode = rmode;
    bwrite(A_CTRL, 0);
    bwrite(A_TOTAL, exp_total);
    bwrite(A_CTRL, dma ? 32'h5 : 32'h1);
    i = 0; guard = 0;
    while (i < n && guard < 4000) begin
      guard++;
      bread(A_USED, u);
      if (dma) begin
        if (dma_req) begin
          // R10: a request means at least half the FIFO is free
          check("R10 room at request", 32'(u <= 32'(DEPTH * 2)), 32'd1);
          for (int b = 0; b < DEPTH / 2 && i < n; b++) begin
            bwrite(A_DATA, pat(seed, i)); i++;
          end
        end
      end else if (u < 32'(DEPTH * 4)) begin
        bwrite(A_DATA, pat(seed, i)); i++;
      end
    end
    wait_irq(400);
    check("R5 irq at completion", 32'(irq), 32'd1);
    check("R3 word count", 32'(rx_cnt), 32'(n));
    check("R3 word data", 32'(rx_bad), 32'd0);
    bread(A_CUR, u);   check("R3 current count", u, 32'(n) * 4);
    bread(A_STAT, u);  check("R6 no error flags", u & 32'hFFFE, 32'd0);
    bwrite(A_CTRL, 0);
    @(negedge clk);
    check("R8 irq cleared", 32'(irq), 32'd0);
    bread(A_USED, u);  check("R8 fifo flushed", u, 32'd0);
  endtask

  initial begin
    #(1_500_000);
    nerr++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 irq", 32'(irq), 32'd0);
    check("R12 dma_req", 32'(dma_req), 32'd0);
    check("R12 tgt_valid", 32'(tgt_valid), 32'd0);
    check("R12 tgt_reset_n", 32'(tgt_reset_n), 32'd1);
    bread(A_CTRL, v); check("R12 control", v, 32'd0);
    bread(A_STAT, v); check("R12 status", v, 32'd0);
    bread(A_SIZE, v); check("R1 fifo size", v, 32'(DEPTH * 4));

    // R2: pushes while disabled are ignored
    bwrite(A_DATA, 32'h1234_5678);
    bwrite(A_DATA, 32'h1234_5679);
    bread(A_USED, v); check("R2 disabled push ignored", v, 32'd0);

    // R1 / R2: fill level with target stalled
    ready_mode = 0; done_auto = 1'b0; tgt_done = 1'b0;
    bwrite(A_TOTAL, 32'd400);
    bwrite(A_CTRL, 32'h1);
    for (int k = 1; k <= 5; k++) begin
      bwrite(A_DATA, 32'(k));
      bread(A_USED, v); check("R1 fifo used", v, 32'(k * 4));
    end
    // R7: overflow
    for (int k = 5; k < DEPTH + 1; k++) bwrite(A_DATA, 32'(k));
    bread(A_USED, v); check("R7 used at full", v, 32'(DEPTH * 4));
    bread(A_STAT, v); check("R7 overflow bit", v, 32'h2);
    @(negedge clk);
    check("R7 irq on overflow", 32'(irq), 32'd1);
    bwrite(A_CTRL, 0);
    @(negedge clk);
    check("R8 irq dropped", 32'(irq), 32'd0);
    bread(A_STAT, v); check("R8 errors cleared", v, 32'd0);

    // R10: request levels in DMA and CPU mode
    bwrite(A_CTRL, 32'h1);
    @(negedge clk); check("R10 no request in CPU mode", 32'(dma_req), 32'd0);
    bwrite(A_CTRL, 0);
    bwrite(A_CTRL, 32'h5);
    for (int k = 0; k <= DEPTH / 2 + 1; k++) begin
      @(negedge clk);
      check("R10 request level", 32'(dma_req), 32'(k <= DEPTH / 2));
      bwrite(A_DATA, 32'(k));
    end
    bwrite(A_CTRL, 0);

    // R4 / R5: total reached, done held low, extra words stay queued
    seed = 32'h77; rx_cnt = 0; rx_bad = 0;
    bwrite(A_TOTAL, 32'd8);
    bwrite(A_CTRL, 32'h1);
    for (int k = 0; k < 4; k++) bwrite(A_DATA, pat(seed, k));
    ready_mode = 1;
    repeat (12) @(negedge clk);
    bread(A_CUR, v);  check("R4 stops at total", v, 32'd8);
    bread(A_USED, v); check("R4 rest stays queued", v, 32'd8);
    check("R4 words delivered", 32'(rx_cnt), 32'd2);
    check("R5 no irq before done", 32'(irq), 32'd0);
    tgt_done = 1'b1;
    bread(A_STAT, v); check("R11 done bit high", v[18], 1'b1);
    repeat (2) @(negedge clk);
    check("R5 irq after done", 32'(irq), 32'd1);
    tgt_done = 1'b0;
    bread(A_STAT, v); check("R11 done bit low", v[18], 1'b0);
    bwrite(A_CTRL, 0);

    // R6: target error with words queued
    ready_mode = 0; rx_cnt = 0;
    bwrite(A_TOTAL, 32'd40);
    bwrite(A_CTRL, 32'h1);
    for (int k = 0; k < 4; k++) bwrite(A_DATA, 32'(k));
    @(negedge clk); tgt_err = 14'h0004;
    @(negedge clk); tgt_err = '0;
    ready_mode = 1;
    repeat (6) @(negedge clk);
    bread(A_STAT, v); check("R6 error bit mapping", v & 32'hFFFE, 32'h10);
    check("R6 irq on error", 32'(irq), 32'd1);
    bread(A_CUR, v);  check("R6 draining halted", v, 32'd0);
    check("R6 no words sent", 32'(rx_cnt), 32'd0);
    bwrite(A_CTRL, 0);

    // R9: reset pulse
    bwrite(A_CTRL, 32'h3);
    check("R9 reset asserted", 32'(tgt_reset_n), 32'd0);
    bwrite(A_CTRL, 0);
    check("R9 reset released", 32'(tgt_reset_n), 32'd1);

    // sweep over image lengths, CPU filling
    for (int n = 1; n <= 20; n++) run_case(n, 1'b0, 2);
    for (int n = 1; n <= 6; n++)  run_case(n, 1'b0, 1);
    // DMA filling
    run_case(5, 1'b1, 2);
    run_case(8, 1'b1, 2);
    run_case(17, 1'b1, 1);
    run_case(24, 1'b1, 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule